// File: doc/BRIEF.md
# Watchdog Reset Supervisor Controller

This block is the digital core of a supply supervisor that also watches a processor. An external comparator supplies an already synchronized supply-good level, and this block turns it into an active-low reset. While supply is lost the reset is held low. Once supply returns, the reset stays low for a selectable release delay and is then released. While the reset is released and the watchdog is enabled, the block expects a level change on the kick input within a selectable timeout. If no change arrives, it pulls the reset low for one release delay and then starts a new timeout. As a result, a processor that never kicks sees a repeating low-high reset pattern.

All times are counted in ticks of a strobe. The parameter `TICKS_PER_MS` gives the number of ticks per millisecond. The kick input passes through a two-flop synchronizer. After that, a level must stay stable for `MIN_PULSE_CYC` clock cycles before it counts as a change. Each accepted change opens a short window of `IGNORE_US` microseconds, converted to ticks, in which later changes are dropped. The enable input, whose active level is the parameter `EN_ACTIVE_HIGH`, switches off only the watchdog; supply supervision keeps running. Loss of supply overrides every other event. A release delay longer than the selected timeout is not a supported setting.

Top module: `wdt_supervisor`

## Requirements
- R1: Whenever `supply_ok_i` is sampled low on a clock edge, `reset_n_o` is low from that edge on, and it stays low while `supply_ok_i` stays low.
- R2: After `supply_ok_i` is sampled high again, `reset_n_o` stays low for exactly N ticks, where N is the release delay selected by `rel_sel_i`, and then goes high.
- R3: Release-delay codes: 0 selects 3.13 ms, rounded to the nearest whole tick (13 ticks at 4 ticks per ms). 1, 2, 3 and 4 select 50, 100, 200 and 400 ms. Codes 5 to 7 behave like code 4.
- R4: Timeout codes: 0 to 5 select 50, 100, 200, 400, 800 and 1600 ms; codes 6 and 7 behave like code 5. With the reset released, the watchdog enabled and no accepted kick, `reset_n_o` falls after exactly T ticks of the selected timeout. A kick input held at a constant level counts as no service.
- R5: After a timeout, `reset_n_o` stays low for exactly N ticks and then a new timeout of T ticks begins, so an unserviced watchdog gives a repeating pattern.
- R6: A rising change and a falling change on `kick_i` are each an accepted service, and each one restarts the timeout count from zero.
- R7: A kick level that lasts fewer than `MIN_PULSE_CYC` clock cycles is not a service. A level that lasts at least that long is a service.
- R8: After an accepted change, further changes are dropped for round(`IGNORE_US`·`TICKS_PER_MS`/1000) ticks.
- R9: While `wd_en_i` is at its inactive level (low when `EN_ACTIVE_HIGH` is 1, high otherwise), no timeout resets occur. Supply loss still forces reset low, and the release delay after recovery is unchanged.
- R10: When `wd_en_i` moves to its active level while the reset is released, a fresh timeout of exactly T ticks starts at once.
- R11: Supply loss during a release delay restarts that delay once supply returns. Kicks and enable changes during a release delay do not shorten it.
- R12: A synchronous reset on `srst_i` puts the block in the supply-lost state with `reset_n_o` low. With supply good, the first release then takes N ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| srst_i | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | Time-base strobe, `TICKS_PER_MS` pulses per millisecond |
| supply_ok_i | input | 1 | Synchronized supply-good level from the comparator |
| kick_i | input | 1 | Watchdog service input, asynchronous |
| wd_en_i | input | 1 | Watchdog enable, active level set by `EN_ACTIVE_HIGH` |
| rel_sel_i | input | 3 | Release-delay select code |
| tmo_sel_i | input | 3 | Watchdog timeout select code |
| reset_n_o | output | 1 | Reset output, low while reset is asserted |

## Verification
The bench measures every delay and timeout as an exact tick count.

- **Rounding and code mapping.** The 3.13 ms code is checked for rounding: a design that truncates would give 12 ticks instead of 13. The out-of-range codes are checked against their clamp values.
- **Falling edges as service.** Kicks arrive at 0.6 of the timeout, so only the falling edges keep the reset high. A design that reacts only to rising edges would reset partway through.
- **Pulse filter.** Two-cycle glitches must leave the timeout at exactly T ticks.
- **Ignore window.** A second change inside the window must not shift the timeout. If the window were missing, the timeout would come about six ticks later.
- **Enable and supply priority.** The bench checks that a disabled watchdog never resets, and that re-enabling it starts a full count. It also checks that supply loss, or kick and enable activity, during a release delay leaves a full delay. A design that let those events through would release early.

// File: rtl/wdt_sup_pkg.sv
package wdt_sup_pkg;

  localparam int unsigned SEL_W = 3;

  typedef enum logic [1:0] {
    SUP_LOST  = 2'd0,
    SUP_HOLD  = 2'd1,
    SUP_WATCH = 2'd2
  } sup_state_e;

  // Release delay in ticks; code 0 is 3.13 ms rounded to the nearest tick.
  function automatic int unsigned release_ticks(input logic [SEL_W-1:0] sel,
                                                input int unsigned tpm);
    int unsigned t;
    case (sel)
      3'd0:    t = (313 * tpm + 50) / 100;
      3'd1:    t = 50 * tpm;
      3'd2:    t = 100 * tpm;
      3'd3:    t = 200 * tpm;
      default: t = 400 * tpm;
    endcase
    if (t == 0) t = 1;
    return t;
  endfunction

  // Watchdog timeout in ticks; every step doubles the previous one.
  function automatic int unsigned timeout_ticks(input logic [SEL_W-1:0] sel,
                                                input int unsigned tpm);
    int unsigned t;
    if (sel > 3'd5) t = 1600 * tpm;
    else            t = (50 * tpm) << sel;
    if (t == 0) t = 1;
    return t;
  endfunction

endpackage

// File: rtl/wdt_kick_filter.sv
module wdt_kick_filter #(
  parameter int unsigned MIN_PULSE_CYC = 30,
  parameter int unsigned IGN_TICKS     = 29
) (
  input  logic clk_i,
  input  logic srst_i,
  input  logic tick_i,
  input  logic kick_i,
  output logic service_o
);
  localparam int unsigned PULSE_LIM = (MIN_PULSE_CYC < 1) ? 1 : MIN_PULSE_CYC;
  localparam int unsigned PW_W      = $clog2(PULSE_LIM + 1);
  localparam int unsigned IGN_W     = $clog2(IGN_TICKS + 2);

  logic [1:0]       sync_q;
  logic             level_q;
  logic [PW_W-1:0]  hold_q;
  logic             change_q;
  logic [IGN_W-1:0] ign_q;

  // Synchronizer, then a level must persist PULSE_LIM cycles to be taken.
  always_ff @(posedge clk_i) begin
    if (srst_i) begin
      sync_q   <= 2'b00;
      level_q  <= 1'b0;
      hold_q   <= '0;
      change_q <= 1'b0;
    end else begin
      sync_q   <= {sync_q[0], kick_i};
      change_q <= 1'b0;
      if (sync_q[1] == level_q) begin
        hold_q <= '0;
      end else if (hold_q >= PW_W'(PULSE_LIM - 1)) begin
        level_q  <= sync_q[1];
        hold_q   <= '0;
        change_q <= 1'b1;
      end else begin
        hold_q <= hold_q + 1'b1;
      end
    end
  end

  // Either direction of change is a service unless the blanking window runs.
  assign service_o = change_q && (ign_q == '0);

  always_ff @(posedge clk_i) begin
    if (srst_i) begin
      ign_q <= '0;
    end else if (service_o) begin
      ign_q <= IGN_W'(IGN_TICKS);
    end else if (tick_i && (ign_q != '0)) begin
      ign_q <= ign_q - 1'b1;
    end
  end

  generate
    if (PULSE_LIM > 1) begin : g_spacing_chk
      // R7: a filtered change needs a stable level, so two cannot be adjacent
      p_change_spacing_r7: assert property (@(posedge clk_i) disable iff (srst_i)
        change_q |=> !change_q);
    end
    if (IGN_TICKS > 0) begin : g_blank_chk
      // R8: an accepted change blanks the next cycle at least
      p_blank_after_service_r8: assert property (@(posedge clk_i) disable iff (srst_i)
        service_o |=> !service_o);
    end
  endgenerate

endmodule

// File: rtl/wdt_timeout_timer.sv
module wdt_timeout_timer
  import wdt_sup_pkg::*;
#(
  parameter int unsigned TICKS_PER_MS = 32,
  parameter int unsigned CNT_W        = 16
) (
  input  logic             clk_i,
  input  logic             srst_i,
  input  logic             tick_i,
  input  logic             active_i,
  input  logic             service_i,
  input  logic [SEL_W-1:0] tmo_sel_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_q;

  assign last_q = CNT_W'(timeout_ticks(tmo_sel_i, TICKS_PER_MS) - 32'd1);

  // Expire on the T-th tick; >= covers a select lowered mid-count.
  assign expire_o = active_i && tick_i && !service_i && (cnt_q >= last_q);

  always_ff @(posedge clk_i) begin
    if (srst_i || !active_i || service_i || expire_o) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R6: a service leaves the count at zero on the next cycle
  p_service_clears_r6: assert property (@(posedge clk_i) disable iff (srst_i)
    service_i |=> (cnt_q == '0));

endmodule

// File: rtl/wdt_reset_seq.sv
module wdt_reset_seq
  import wdt_sup_pkg::*;
#(
  parameter int unsigned TICKS_PER_MS = 32,
  parameter int unsigned CNT_W        = 16
) (
  input  logic             clk_i,
  input  logic             srst_i,
  input  logic             tick_i,
  input  logic             supply_ok_i,
  input  logic             expire_i,
  input  logic [SEL_W-1:0] rel_sel_i,
  output logic             watching_o,
  output logic             reset_n_o
);
  sup_state_e       state_q;
  logic [CNT_W-1:0] dly_q;
  logic [CNT_W-1:0] dly_last;

  assign dly_last = CNT_W'(release_ticks(rel_sel_i, TICKS_PER_MS) - 32'd1);

  always_ff @(posedge clk_i) begin
    if (srst_i || !supply_ok_i) begin
      state_q <= SUP_LOST;
      dly_q   <= '0;
    end else begin
      case (state_q)
        SUP_LOST: begin
          state_q <= SUP_HOLD;
          dly_q   <= '0;
        end
        SUP_HOLD: begin
          if (tick_i) begin
            if (dly_q >= dly_last) begin
              state_q <= SUP_WATCH;
              dly_q   <= '0;
            end else begin
              dly_q <= dly_q + 1'b1;
            end
          end
        end
        SUP_WATCH: begin
          if (expire_i) begin
            state_q <= SUP_HOLD;
            dly_q   <= '0;
          end
        end
        default: begin
          state_q <= SUP_LOST;
          dly_q   <= '0;
        end
      endcase
    end
  end

  assign watching_o = (state_q == SUP_WATCH);
  assign reset_n_o  = watching_o;

  // R1: supply loss drives reset low by the next cycle
  p_loss_forces_low_r1: assert property (@(posedge clk_i) disable iff (srst_i)
    !supply_ok_i |=> !reset_n_o);

  // R5: a watchdog expiry starts a reset pulse
  p_expire_forces_low_r5: assert property (@(posedge clk_i) disable iff (srst_i)
    expire_i |=> !reset_n_o);

  // R2: reset only releases with supply good
  p_release_needs_supply_r2: assert property (@(posedge clk_i) disable iff (srst_i)
    $rose(reset_n_o) |-> $past(supply_ok_i));

endmodule

// File: rtl/wdt_supervisor.sv
module wdt_supervisor
  import wdt_sup_pkg::*;
#(
  parameter int unsigned TICKS_PER_MS   = 32,
  parameter int unsigned MIN_PULSE_CYC  = 30,
  parameter int unsigned IGNORE_US      = 900,
  parameter bit          EN_ACTIVE_HIGH = 1'b1
) (
  input  logic             clk_i,
  input  logic             srst_i,
  input  logic             tick_i,
  input  logic             supply_ok_i,
  input  logic             kick_i,
  input  logic             wd_en_i,
  input  logic [SEL_W-1:0] rel_sel_i,
  input  logic [SEL_W-1:0] tmo_sel_i,
  output logic             reset_n_o
);
  localparam int unsigned CNT_W     = $clog2(1600 * TICKS_PER_MS + 1);
  localparam int unsigned IGN_TICKS = (IGNORE_US * TICKS_PER_MS + 500) / 1000;

  logic wd_on;
  logic watching;
  logic service;
  logic expire;

  assign wd_on = (wd_en_i == EN_ACTIVE_HIGH);

  wdt_kick_filter #(
    .MIN_PULSE_CYC (MIN_PULSE_CYC),
    .IGN_TICKS     (IGN_TICKS)
  ) u_kick (
    .clk_i     (clk_i),
    .srst_i    (srst_i),
    .tick_i    (tick_i),
    .kick_i    (kick_i),
    .service_o (service)
  );

  wdt_timeout_timer #(
    .TICKS_PER_MS (TICKS_PER_MS),
    .CNT_W        (CNT_W)
  ) u_timer (
    .clk_i     (clk_i),
    .srst_i    (srst_i),
    .tick_i    (tick_i),
    .active_i  (watching && wd_on),
    .service_i (service),
    .tmo_sel_i (tmo_sel_i),
    .expire_o  (expire)
  );

  wdt_reset_seq #(
    .TICKS_PER_MS (TICKS_PER_MS),
    .CNT_W        (CNT_W)
  ) u_seq (
    .clk_i       (clk_i),
    .srst_i      (srst_i),
    .tick_i      (tick_i),
    .supply_ok_i (supply_ok_i),
    .expire_i    (expire),
    .rel_sel_i   (rel_sel_i),
    .watching_o  (watching),
    .reset_n_o   (reset_n_o)
  );

  // R9: with the watchdog off, a released reset stays released while supply holds
  p_off_keeps_release_r9: assert property (@(posedge clk_i) disable iff (srst_i)
    (reset_n_o && !wd_on && supply_ok_i) |=> reset_n_o);

endmodule

// File: tb/test_wdt_supervisor.sv
module test_wdt_supervisor;
  localparam int unsigned TPM    = 4;
  localparam int unsigned MINP   = 3;
  localparam int unsigned IGN_US = 2500;   // 10 ticks of blanking

  logic       clk = 1'b0;
  logic       srst = 1'b1;
  logic       tick = 1'b0;
  logic       supply_ok = 1'b1;
  logic       kick = 1'b0;
  logic       wd_en = 1'b1;
  logic [2:0] rel_sel = 3'd0;
  logic [2:0] tmo_sel = 3'd0;
  logic       reset_n;

  int n_checks = 0;
  int n_fail   = 0;
  int tdiv     = 0;
  bit done     = 1'b0;
  int cnt_a;
  int cnt_b;

  // vector table: release code, timeout code, expected N and T in ticks
  localparam int NV = 7;
  localparam logic [2:0] V_REL [NV] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd0, 3'd7};
  localparam logic [2:0] V_TMO [NV] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6};
  localparam int V_N [NV] = '{13, 200, 400, 800, 1600, 13, 1600};
  localparam int V_T [NV] = '{200, 400, 800, 1600, 3200, 6400, 6400};

  always #5 clk = ~clk;

  // tick every second clock, driven on the falling edge
  always @(negedge clk) begin
    tdiv = (tdiv + 1) % 2;
    tick = (tdiv == 0);
  end

  wdt_supervisor #(
    .TICKS_PER_MS   (TPM),
    .MIN_PULSE_CYC  (MINP),
    .IGNORE_US      (IGN_US),
    .EN_ACTIVE_HIGH (1'b1)
  ) i_wdt_supervisor (
    .clk_i       (clk),
    .srst_i      (srst),
    .tick_i      (tick),
    .supply_ok_i (supply_ok),
    .kick_i      (kick),
    .wd_en_i     (wd_en),
    .rel_sel_i   (rel_sel),
    .tmo_sel_i   (tmo_sel),
    .reset_n_o   (reset_n)
  );

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    n_checks++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic samp;
    @(negedge clk);
    #1;
  endtask

  // count ticks while reset_n holds lvl; called at a sample point
  task automatic phase(input logic lvl, input int maxc, output int cnt);
    cnt = 0;
    for (int i = 0; i < maxc; i++) begin
      if (reset_n !== lvl) break;
      if (tick) cnt++;
      samp();
    end
  endtask

  // returns 1 if reset_n was seen low during ncyc sample points
  task automatic watch(input int ncyc, output int low_seen);
    low_seen = 0;
    for (int i = 0; i < ncyc; i++) begin
      samp();
      if (!reset_n) low_seen = 1;
    end
  endtask

  // power cycle and wait through the release delay; ends in watch state
  task automatic start_run(input logic [2:0] r, input logic [2:0] t);
    int c;
    @(negedge clk);
    rel_sel = r;
    tmo_sel = t;
    supply_ok = 1'b0;
    @(negedge clk);
    supply_ok = 1'b1;
    samp();
    phase(1'b0, 4000, c);
  endtask

  initial begin
    int lw;
    // R12: reset state and first release
    repeat (4) @(negedge clk);
    #1;
    chk("R12 reset holds output low", int'(reset_n), 0);
    @(negedge clk);
    srst = 1'b0;
    samp();
    phase(1'b0, 100, cnt_a);
    chk("R12 first release after reset", cnt_a, 13);

    // vector table: R1..R5 across codes
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      rel_sel = V_REL[v];
      tmo_sel = V_TMO[v];
      supply_ok = 1'b0;
      repeat (3) samp();
      chk("R1 low during supply loss", int'(reset_n), 0);
      @(negedge clk);
      supply_ok = 1'b1;
      samp();
      phase(1'b0, 2 * V_N[v] + 100, cnt_a);
      chk("R2/R3 release delay ticks", cnt_a, V_N[v]);
      phase(1'b1, 2 * V_T[v] + 100, cnt_b);
      chk("R4 timeout ticks", cnt_b, V_T[v]);
      phase(1'b0, 2 * V_N[v] + 100, cnt_a);
      chk("R5 repeated reset pulse ticks", cnt_a, V_N[v]);
    end

    // R1: supply loss in watch state
    start_run(3'd0, 3'd0);
    samp();
    @(negedge clk);
    supply_ok = 1'b0;
    samp();
    chk("R1 loss while released", int'(reset_n), 0);
    @(negedge clk);
    supply_ok = 1'b1;

    // R6: both directions service (period 0.6 T)
    start_run(3'd0, 3'd0);
    lw = 0;
    for (int k = 0; k < 8; k++) begin
      watch(240, cnt_a);
      if (cnt_a != 0) lw = 1;
      kick = ~kick;
    end
    chk("R6 both edges keep reset released", lw, 0);
    samp();
    phase(1'b1, 2000, cnt_b);
    chk_rng("R6 timeout restarts from last edge", cnt_b, 200, 206);

    // R7: glitches shorter than MIN_PULSE_CYC are not service
    start_run(3'd0, 3'd0);
    fork
      phase(1'b1, 2000, cnt_a);
      begin
        for (int k = 0; k < 6; k++) begin
          repeat (98) @(negedge clk);
          kick = ~kick;
          repeat (MINP - 1) @(negedge clk);
          kick = ~kick;
        end
      end
    join
    chk("R7 short glitches ignored", cnt_a, 200);

    // R7: a pulse of MIN_PULSE_CYC cycles is service
    start_run(3'd0, 3'd0);
    fork
      phase(1'b1, 2000, cnt_a);
      begin
        repeat (100) @(negedge clk);
        kick = ~kick;
        repeat (MINP) @(negedge clk);
        kick = ~kick;
      end
    join
    chk_rng("R7 full-width pulse accepted", cnt_a, 251, 255);

    // R8: second change 6 ticks later falls in the blanking window
    start_run(3'd0, 3'd0);
    fork
      phase(1'b1, 2000, cnt_a);
      begin
        repeat (100) @(negedge clk);
        kick = ~kick;
        repeat (12) @(negedge clk);
        kick = ~kick;
      end
    join
    chk_rng("R8 change inside window ignored", cnt_a, 251, 255);

    // R9: watchdog off
    start_run(3'd0, 3'd0);
    wd_en = 1'b0;
    watch(1200, lw);
    chk("R9 no timeout while disabled", lw, 0);
    @(negedge clk);
    supply_ok = 1'b0;
    samp();
    chk("R9 supply loss still resets", int'(reset_n), 0);
    @(negedge clk);
    supply_ok = 1'b1;
    samp();
    phase(1'b0, 200, cnt_a);
    chk("R9 release delay while disabled", cnt_a, 13);
    watch(1000, lw);
    chk("R9 stays released while disabled", lw, 0);

    // R10: enabling starts a full count
    @(negedge clk);
    wd_en = 1'b1;
    #1;
    phase(1'b1, 2000, cnt_b);
    chk("R10 fresh timeout after enable", cnt_b, 200);

    // R11: supply loss mid-delay restarts, kicks and enable do not shorten
    @(negedge clk);
    rel_sel = 3'd2;
    tmo_sel = 3'd4;
    supply_ok = 1'b0;
    @(negedge clk);
    supply_ok = 1'b1;
    repeat (200) @(negedge clk);
    supply_ok = 1'b0;
    @(negedge clk);
    supply_ok = 1'b1;
    samp();
    fork
      phase(1'b0, 2000, cnt_a);
      begin
        for (int k = 0; k < 30; k++) begin
          repeat (20) @(negedge clk);
          kick = ~kick;
          if (k % 5 == 0) wd_en = ~wd_en;
        end
        wd_en = 1'b1;
      end
    join
    chk("R11 full delay despite loss, kicks, enable", cnt_a, 400);

    // R12: synchronous reset in watch state
    @(negedge clk);
    srst = 1'b1;
    samp();
    chk("R12 reset pulls output low", int'(reset_n), 0);
    @(negedge clk);
    srst = 1'b0;

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #1900000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule